// File: doc/BRIEF.md
# Fuse Sense and Load Sequencer

This block runs one sense-and-load pass over a fuse array. A pass begins either by itself when power-on reset is released, or when a request input sees a rising edge. A chain of three token bits then walks through the pass. Each bit waits a long time before it sets and only a short time before it clears, which models a slow-rise, fast-fall delay element with a fast free-running clock and small counters. The outputs that drive the fuse cells and the latches are decoded from the token bits.

The strobes come in a fixed order. First the fuse clear strobe (active low) goes low. Then the precharge/set strobe pulses. Then the path select moves the latches onto their parallel-load path while the load strobe is high. This last step captures the sensed fuse values into the readout shift register and the configuration latches. A one-cycle done pulse closes each pass. A request edge that arrives while a pass is running has no effect. The fuse sensing itself is analog and is not part of this block.

Top module: `fuse_sense_seq`

## Requirements
- R1: While `rst_n` is low, including when it is driven low in the middle of a pass, `fuse_clr_n` is 1 and `fuse_setp`, `path_sel`, `latch_load` and `seq_done` are 0 without waiting for a clock edge.
- R2: After `rst_n` is released, a pass starts without any request edge. `fuse_clr_n` first reads low right after the fifth rising clock edge that follows the first edge seeing `rst_n` high. Counting that first edge as edge 0, this is edge 5.
- R3: A rising edge of `sense_req` starts a pass when the block is idle. With the first edge that samples `sense_req` high counted as edge 0, `fuse_clr_n` first reads low after edge 5. A pulse one cycle wide is enough. Holding the request high starts no second pass.
- R4: Within a pass the order is: `fuse_clr_n` low, then `fuse_setp` high, then `latch_load` high, then `seq_done`. At most one of (`fuse_clr_n` low, `fuse_setp`, `latch_load`) is active in any cycle.
- R5: Each token bit sets RISE_CYC cycles after its predecessor (default 3). `fuse_clr_n` is low for exactly RISE_CYC cycles, and `fuse_setp` follows at once for exactly RISE_CYC cycles.
- R6: Token bits clear FALL_CYC cycles apart (default 1). `latch_load` stays high for 1 + 3*FALL_CYC cycles (default 4). `path_sel` equals `latch_load` in every cycle.
- R7: `seq_done` is high for exactly one cycle per pass: the first cycle in which `latch_load` reads low again.
- R8: A rising edge of `sense_req` seen while a pass is running is ignored. The pass keeps its timing and produces a single `seq_done`. A new edge after the pass has finished starts a new pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running modelling clock |
| rst_n | input | 1 | Power-on reset, active low, asserted asynchronously, released synchronously inside |
| sense_req | input | 1 | Sense request; its rising edge starts a pass (synchronised inside) |
| fuse_clr_n | output | 1 | Fuse clear strobe, active low |
| fuse_setp | output | 1 | Fuse precharge/set strobe, active high |
| path_sel | output | 1 | Selects the parallel-load path of the latches |
| latch_load | output | 1 | Load strobe for readout register and latches |
| seq_done | output | 1 | One-cycle pulse at the end of each pass |

## Verification
Passes are started in four ways: by reset release, by a request held high, by a request one cycle wide, and by a request that drops and rises again during the pass. The first three show that the power-on start and the edge start reach the same strobe timing, and that a level does not retrigger. The fourth tells an ignored busy edge apart from a restart, because a restart would add a second done pulse or stretch a strobe. Reset asserted in the middle of a pass shows that the asynchronous clear reaches the outputs and that the pass which follows is a fresh power-on pass.

// File: rtl/fsq_pkg.sv
`timescale 1ns/1ps
package fsq_pkg;
  localparam int unsigned FSQ_STAGES = 3;

  typedef struct packed {
    logic clr_n;
    logic setp;
    logic sel;
    logic load;
  } fsq_strobe_t;
endpackage

// File: rtl/fsq_rst_sync.sv
`timescale 1ns/1ps
module fsq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/fsq_edge_det.sv
`timescale 1ns/1ps
module fsq_edge_det #(
  parameter int unsigned SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [SYNC:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SYNC-1:0], din};
  end

  assign rise = sh_q[SYNC-1] & ~sh_q[SYNC];
endmodule

// File: rtl/fsq_token_bit.sv
`timescale 1ns/1ps
module fsq_token_bit #(
  parameter int unsigned RISE_CYC = 3,
  parameter int unsigned FALL_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgt_i,
  output logic q_o
);
  localparam int unsigned MAXD = (RISE_CYC > FALL_CYC) ? RISE_CYC : FALL_CYC;
  localparam int unsigned CW   = $clog2(MAXD + 1);
  localparam logic [CW-1:0] LIM_RISE = CW'(RISE_CYC - 1);
  localparam logic [CW-1:0] LIM_FALL = CW'(FALL_CYC - 1);

  logic          q_q, q_nxt;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic [CW-1:0] lim;

  always_comb begin
    q_nxt   = q_q;
    cnt_nxt = '0;
    lim     = q_q ? LIM_FALL : LIM_RISE;
    if (q_q != tgt_i) begin
      if (cnt_q == lim) q_nxt   = tgt_i;
      else              cnt_nxt = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q   <= 1'b0;
      cnt_q <= '0;
    end else begin
      q_q   <= q_nxt;
      cnt_q <= cnt_nxt;
    end
  end

  assign q_o = q_q;

  // R5/R6: a token bit only ever moves toward its target
  p_toward_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (q_q != $past(q_q)) |-> (q_q == $past(tgt_i)));
endmodule

// File: rtl/fuse_sense_seq.sv
`timescale 1ns/1ps
module fuse_sense_seq #(
  parameter int unsigned RISE_CYC    = 3,
  parameter int unsigned FALL_CYC    = 1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sense_req,
  output logic fuse_clr_n,
  output logic fuse_setp,
  output logic path_sel,
  output logic latch_load,
  output logic seq_done
);
  import fsq_pkg::*;

  localparam int unsigned NS   = FSQ_STAGES;
  localparam int unsigned LAST = NS - 1;

  logic          rst_s_n;
  logic          sense_rise;
  logic          run_q, run_nxt;
  logic          por_q, por_nxt;
  logic          last_d_q;
  logic          idle, start;
  logic [NS-1:0] tok;
  logic [NS-1:0] tgt;
  fsq_strobe_t   stb;

  fsq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(rst_s_n)
  );

  fsq_edge_det #(.SYNC(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_s_n), .din(sense_req), .rise(sense_rise)
  );

  // token chain: bit 0 follows the run flag, each later bit follows its predecessor
  for (genvar i = 0; i < NS; i++) begin : g_tok
    if (i == 0) begin : g_head
      assign tgt[i] = run_q;
    end else begin : g_link
      assign tgt[i] = tok[i-1];
    end
    fsq_token_bit #(.RISE_CYC(RISE_CYC), .FALL_CYC(FALL_CYC)) u_bit (
      .clk(clk), .rst_n(rst_s_n), .tgt_i(tgt[i]), .q_o(tok[i])
    );
  end

  always_comb begin
    idle    = ~run_q & ~(|tok);
    start   = idle & (sense_rise | por_q);
    por_nxt = por_q & ~start;
    run_nxt = run_q;
    if (start)          run_nxt = 1'b1;
    else if (tok[LAST]) run_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      run_q    <= 1'b0;
      por_q    <= 1'b1;
      last_d_q <= 1'b0;
    end else begin
      run_q    <= run_nxt;
      por_q    <= por_nxt;
      last_d_q <= tok[LAST];
    end
  end

  always_comb begin
    stb.clr_n = ~(tok[0] & ~tok[1]);
    stb.setp  = tok[1] & ~tok[LAST];
    stb.sel   = tok[LAST];
    stb.load  = tok[LAST];
  end

  assign fuse_clr_n = stb.clr_n;
  assign fuse_setp  = stb.setp;
  assign path_sel   = stb.sel;
  assign latch_load = stb.load;
  assign seq_done   = last_d_q & ~tok[LAST];

  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0({~fuse_clr_n, fuse_setp, latch_load}));

  p_clr_before_setp_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(fuse_setp) |-> $past(!fuse_clr_n));

  p_setp_before_load_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(latch_load) |-> $past(fuse_setp));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    seq_done |=> !seq_done);

  p_done_after_load_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    seq_done |-> ($past(latch_load) && !latch_load));

  p_busy_ignored_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (sense_rise && latch_load) |=> !(fuse_clr_n == 1'b0));
endmodule

// File: tb/tb_fuse_sense_seq.sv
`timescale 1ns/1ps
module tb_fuse_sense_seq;
  localparam int RISE = 3;
  localparam int FALL = 1;

  logic clk = 1'b0;
  logic rst_n;
  logic sense_req;
  logic fuse_clr_n, fuse_setp, path_sel, latch_load, seq_done;

  int checks = 0;
  int errors = 0;

  int first_clr, n_clr, first_setp, n_setp, first_load, n_load;
  int first_done, n_done, n_excl, n_selbad;

  always #4 clk = ~clk;

  fuse_sense_seq #(.RISE_CYC(RISE), .FALL_CYC(FALL)) dut (
    .clk(clk), .rst_n(rst_n), .sense_req(sense_req),
    .fuse_clr_n(fuse_clr_n), .fuse_setp(fuse_setp), .path_sel(path_sel),
    .latch_load(latch_load), .seq_done(seq_done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Samples after each of ncyc edges; index k means after edge k.
  // sense is dropped for edges in [lo,hi) when drive is set.
  task automatic watch(input int ncyc, input int lo, input int hi, input bit drive);
    first_clr = -1; first_setp = -1; first_load = -1; first_done = -1;
    n_clr = 0; n_setp = 0; n_load = 0; n_done = 0; n_excl = 0; n_selbad = 0;
    for (int k = 0; k < ncyc; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (!fuse_clr_n) begin if (first_clr  < 0) first_clr  = k; n_clr++;  end
      if (fuse_setp)   begin if (first_setp < 0) first_setp = k; n_setp++; end
      if (latch_load)  begin if (first_load < 0) first_load = k; n_load++; end
      if (seq_done)    begin if (first_done < 0) first_done = k; n_done++; end
      if ((!fuse_clr_n + fuse_setp + latch_load) > 1) n_excl++;
      if (path_sel != latch_load) n_selbad++;
      if (drive) sense_req = !((k + 1 >= lo) && (k + 1 < hi));
    end
  endtask

  task automatic check_pass(input string req_start);
    int t_clr  = 5;
    int t_setp = t_clr + RISE;
    int t_load = t_setp + RISE;
    int w_load = 1 + 3 * FALL;
    check(first_clr == t_clr, req_start, "clear strobe start edge", first_clr, t_clr);
    check(n_clr == RISE, "R5", "clear strobe width", n_clr, RISE);
    check(first_setp == t_setp, "R5", "precharge start edge", first_setp, t_setp);
    check(n_setp == RISE, "R5", "precharge width", n_setp, RISE);
    check(first_load == t_load, "R4", "load start edge", first_load, t_load);
    check(n_load == w_load, "R6", "load width", n_load, w_load);
    check(n_selbad == 0, "R6", "path_sel differs from load", n_selbad, 0);
    check(n_excl == 0, "R4", "overlapping strobes", n_excl, 0);
    check(first_done == t_load + w_load, "R7", "done edge", first_done, t_load + w_load);
    check(n_done == 1, "R7", "done pulses", n_done, 1);
  endtask

  task automatic idle_low(input int n);
    sense_req = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    sense_req = 1'b0;
    repeat (3) @(negedge clk);
    sense_req = 1'b1;
    repeat (3) @(negedge clk);
    check(fuse_clr_n == 1'b1, "R1", "clr_n in reset", fuse_clr_n, 1);
    check(fuse_setp == 1'b0, "R1", "setp in reset", fuse_setp, 0);
    check(path_sel == 1'b0 && latch_load == 1'b0, "R1", "sel/load in reset",
          path_sel + latch_load, 0);
    check(seq_done == 1'b0, "R1", "done in reset", seq_done, 0);
    sense_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_power_on();
    rst_n = 1'b1;
    watch(30, 0, 0, 1'b0);
    check_pass("R2");
  endtask

  task automatic t_sense_held();
    idle_low(5);
    sense_req = 1'b1;
    watch(45, -1, -1, 1'b1);
    check_pass("R3");
    check(n_clr == RISE, "R3", "held request retriggered", n_clr, RISE);
  endtask

  task automatic t_sense_short();
    idle_low(5);
    sense_req = 1'b1;
    watch(30, 1, 1000, 1'b1);
    check_pass("R3");
  endtask

  task automatic t_busy_edge();
    idle_low(5);
    sense_req = 1'b1;
    watch(45, 4, 7, 1'b1);
    check_pass("R3");
    check(n_done == 1, "R8", "busy edge caused extra pass", n_done, 1);
    // a fresh edge after the pass must start again
    idle_low(5);
    sense_req = 1'b1;
    watch(30, -1, -1, 1'b1);
    check(first_clr == 5, "R8", "restart after done", first_clr, 5);
    check(n_done == 1, "R8", "restart done pulses", n_done, 1);
  endtask

  task automatic t_mid_reset();
    idle_low(5);
    sense_req = 1'b1;
    repeat (12) @(negedge clk);
    check(latch_load == 1'b1, "R4", "load mid pass before reset", latch_load, 1);
    rst_n = 1'b0;
    #1;
    check(latch_load == 1'b0 && path_sel == 1'b0, "R1", "async clear of load",
          latch_load + path_sel, 0);
    check(fuse_clr_n == 1'b1 && fuse_setp == 1'b0, "R1", "async clear of clr/setp",
          fuse_clr_n, 1);
    sense_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    watch(30, 0, 0, 1'b0);
    check_pass("R2");
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0;
    sense_req = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_power_on();
    t_sense_held();
    t_sense_short();
    t_busy_edge();
    t_mid_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule